// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number plus an offset, into a physical address. It holds a small on-chip segment table. Each entry stores a base physical address, a segment length and three access-permission bits. A separate length register sets how many table entries are currently legal. Table entries and the length register can be loaded only while the privileged qualifier is asserted on the configuration port.

Each access request carries a segment number, an offset and an access type. The block applies three checks in order. The segment number must be within the table length. The offset must be within the segment. The access type must be permitted by the entry. If all three pass, the physical address is formed by adding the offset to the segment base. The response is registered: it is either a physical address or a fault with a two-bit cause code.

Top module: `seg_xlat`

## Requirements
- R1: After reset the length register is 0, all entries are zero and the response outputs are zero, so any request faults with cause 2'b01.
- R2: A segment number is legal only when it is strictly less than the length register; otherwise the response faults with cause 2'b01.
- R3: An offset greater than or equal to the entry's limit (the segment length) faults with cause 2'b10.
- R4: Permission bits are perm[0]=read, perm[1]=write, perm[2]=execute. The access type codes are 0=read, 1=write, 2=execute and 3=reserved, and the reserved type is never permitted. A type that is not permitted faults with cause 2'b11.
- R5: When several checks fail, the reported cause follows this priority: segment number (2'b01) first, then limit (2'b10), then permission (2'b11).
- R6: A legal access reports fault=0, cause 2'b00 and a physical address equal to base + offset, taken modulo 2^PA_W.
- R7: Each request gets its response exactly one cycle later. In a cycle after no request, rsp_valid is 0 and all response outputs are 0.
- R8: Whenever a fault is reported, the physical address output is 0.
- R9: Writes to an entry or to the length register that arrive with cfg_priv low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_priv | input | 1 | Privilege qualifier for all configuration writes |
| cfg_ent_we | input | 1 | Write enable for the table entry selected by cfg_idx |
| cfg_idx | input | SEG_W (3) | Index of the entry to write |
| cfg_base | input | PA_W (12) | Base physical address to write |
| cfg_limit | input | OFF_W+1 (9) | Segment length to write |
| cfg_perm | input | 3 | Permission bits to write: read, write, execute |
| cfg_len_we | input | 1 | Write enable for the length register |
| cfg_len | input | SEG_W+1 (4) | Value for the length register |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | SEG_W (3) | Segment number of the request |
| req_off | input | OFF_W (8) | Offset within the segment |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_fault | output | 1 | The request faulted |
| rsp_cause | output | 2 | Cause code: 00 ok, 01 segment, 10 limit, 11 permission |
| rsp_paddr | output | PA_W (12) | Physical address, or 0 on a fault |

## Verification
Every response is due on the clock edge that follows the edge where the request was sampled. The bench drives each request just after a falling edge. It then reads the response at the next falling edge, which lies half a period after that capturing rising edge. Configuration writes take effect at the edge that captures them, so the bench always allows at least one edge between a write and a request that depends on it. The checks made after the unprivileged writes also read the state through ordinary requests, one cycle after each request is issued.

// File: rtl/segx_pkg.sv
package segx_pkg;
    parameter int SEG_W = 3;
    parameter int OFF_W = 8;
    parameter int PA_W  = 12;
    localparam int NSEG  = 1 << SEG_W;
    localparam int LIM_W = OFF_W + 1;
    localparam int LEN_W = SEG_W + 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_SEG   = 2'b01,
        FLT_LIMIT = 2'b10,
        FLT_PERM  = 2'b11
    } cause_t;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
        logic [2:0]       perm;
    } seg_ent_t;

    function automatic logic perm_ok(input logic [2:0] perm, input acc_t acc);
        case (acc)
            ACC_READ:  perm_ok = perm[0];
            ACC_WRITE: perm_ok = perm[1];
            ACC_EXEC:  perm_ok = perm[2];
            default:   perm_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_priv,
    input  logic             cfg_ent_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  seg_ent_t         cfg_ent,
    input  logic             cfg_len_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_ent_t         rd_ent,
    output logic [LEN_W-1:0] seg_len
);
    seg_ent_t ents [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (cfg_priv && cfg_ent_we && cfg_idx == SEG_W'(g))
                ents[g] <= cfg_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seg_len <= '0;
        else if (cfg_priv && cfg_len_we)
            seg_len <= cfg_len;
    end

    assign rd_ent = ents[rd_idx];

    // R9: without privilege the length register cannot move
    a_r9_len_priv: assert property (@(posedge clk) disable iff (rst)
        !cfg_priv |=> $stable(seg_len));
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  acc_t             acc,
    input  seg_ent_t         ent,
    input  logic [LEN_W-1:0] seg_len,
    output cause_t           cause,
    output logic [PA_W-1:0]  paddr
);
    logic seg_bad, lim_bad, perm_bad;

    always_comb begin
        seg_bad  = {1'b0, seg} >= seg_len;
        lim_bad  = {1'b0, off} >= ent.limit;
        perm_bad = !perm_ok(ent.perm, acc);
        if (seg_bad)       cause = FLT_SEG;
        else if (lim_bad)  cause = FLT_LIMIT;
        else if (perm_bad) cause = FLT_PERM;
        else               cause = FLT_NONE;
        paddr = (cause == FLT_NONE) ? ent.base + PA_W'(off) : '0;
    end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import segx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_priv,
    input  logic                 cfg_ent_we,
    input  logic [SEG_W-1:0]     cfg_idx,
    input  logic [PA_W-1:0]      cfg_base,
    input  logic [OFF_W:0]       cfg_limit,
    input  logic [2:0]           cfg_perm,
    input  logic                 cfg_len_we,
    input  logic [SEG_W:0]       cfg_len,
    input  logic                 req_valid,
    input  logic [SEG_W-1:0]     req_seg,
    input  logic [OFF_W-1:0]     req_off,
    input  logic [1:0]           req_type,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [1:0]           rsp_cause,
    output logic [PA_W-1:0]      rsp_paddr
);
    seg_ent_t         wr_ent, rd_ent;
    logic [LEN_W-1:0] seg_len;
    cause_t           cause;
    logic [PA_W-1:0]  paddr;

    assign wr_ent = '{base: cfg_base, limit: cfg_limit, perm: cfg_perm};

    seg_table u_table (
        .clk(clk), .rst(rst), .cfg_priv(cfg_priv),
        .cfg_ent_we(cfg_ent_we), .cfg_idx(cfg_idx), .cfg_ent(wr_ent),
        .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .rd_idx(req_seg), .rd_ent(rd_ent), .seg_len(seg_len)
    );

    seg_check u_check (
        .seg(req_seg), .off(req_off), .acc(acc_t'(req_type)),
        .ent(rd_ent), .seg_len(seg_len), .cause(cause), .paddr(paddr)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= 2'b00;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= (cause != FLT_NONE);
            rsp_cause <= cause;
            rsp_paddr <= paddr;
        end
    end

    // R7: one response per request, one cycle later
    a_r7_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_cause == 2'b00 && rsp_paddr == '0));
    // R8: a fault never carries an address
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_paddr == '0);
    // R2: out-of-range segment number yields the segment cause
    a_r2_bad_seg: assert property (@(posedge clk) disable iff (rst)
        (req_valid && {1'b0, req_seg} >= seg_len) |=> rsp_cause == 2'b01);
    // R5: fault flag agrees with a nonzero cause
    a_r5_flag_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)));
endmodule

// File: tb/seg_xlat_tb.sv
module seg_xlat_tb;
    localparam int SW = 3, OW = 8, PW = 12, N = 8;

    logic clk = 0, rst = 1;
    logic cfg_priv = 0, cfg_ent_we = 0, cfg_len_we = 0;
    logic [SW-1:0] cfg_idx = '0;
    logic [PW-1:0] cfg_base = '0;
    logic [OW:0]   cfg_limit = '0;
    logic [2:0]    cfg_perm = '0;
    logic [SW:0]   cfg_len = '0;
    logic req_valid = 0;
    logic [SW-1:0] req_seg = '0;
    logic [OW-1:0] req_off = '0;
    logic [1:0]    req_type = '0;
    logic rsp_valid, rsp_fault;
    logic [1:0] rsp_cause;
    logic [PW-1:0] rsp_paddr;

    int errors = 0, checks = 0;
    int mb [N];
    int ml [N];
    int mp [N];
    int mlen = 0;

    always #10 clk = ~clk;

    seg_xlat u_dut (
        .clk(clk), .rst(rst), .cfg_priv(cfg_priv), .cfg_ent_we(cfg_ent_we),
        .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_perm(cfg_perm), .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_type(req_type), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ent(input bit priv, input int i, input int b, input int l, input int p);
        cfg_priv = priv; cfg_ent_we = 1; cfg_idx = SW'(i);
        cfg_base = PW'(b); cfg_limit = (OW+1)'(l); cfg_perm = 3'(p);
        @(negedge clk);
        cfg_ent_we = 0; cfg_priv = 0;
    endtask

    task automatic wr_len(input bit priv, input int l);
        cfg_priv = priv; cfg_len_we = 1; cfg_len = (SW+1)'(l);
        @(negedge clk);
        cfg_len_we = 0; cfg_priv = 0;
    endtask

    // issue one request and check the response one cycle later
    task automatic access(input string req, input int s, input int o, input int t);
        int ec, ea;
        bit pok;
        req_valid = 1; req_seg = SW'(s); req_off = OW'(o); req_type = 2'(t);
        pok = (t == 0) ? mp[s][0] : (t == 1) ? mp[s][1] : (t == 2) ? mp[s][2] : 1'b0;
        if (s >= mlen)      ec = 1;
        else if (o >= ml[s]) ec = 2;
        else if (!pok)      ec = 3;
        else                ec = 0;
        ea = (ec == 0) ? ((mb[s] + o) % (1 << PW)) : 0;
        @(negedge clk);
        req_valid = 0;
        chk({req, " valid"}, int'(rsp_valid), 1);
        chk({req, " cause"}, int'(rsp_cause), ec);
        chk({req, " fault"}, int'(rsp_fault), int'(ec != 0));
        chk({req, " paddr"}, int'(rsp_paddr), ea);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mb[i] = 0; ml[i] = 0; mp[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_paddr", int'(rsp_paddr), 0);
        access("R1 seg0 after reset", 0, 0, 0);
        @(negedge clk);
        chk("R7 idle valid", int'(rsp_valid), 0);
        chk("R7 idle cause", int'(rsp_cause), 0);

        // privileged configuration
        for (int i = 0; i < N; i++) begin
            mb[i] = (i * 523 + 17) % 4096;
            ml[i] = (i == 7) ? 256 : (i * 37 + 5);
            mp[i] = i;
            wr_ent(1, i, mb[i], ml[i], mp[i]);
        end
        mlen = 6;
        wr_len(1, mlen);
        // base near top exercises wrap (R6)
        mb[5] = 4090; wr_ent(1, 5, mb[5], ml[5], mp[5]);

        // sweep: R2 R3 R4 R5 R6 R8
        for (int s = 0; s < N; s++)
            for (int t = 0; t < 4; t++) begin
                access("R2/R4/R5/R6/R8 offset 0", s, 0, t);
                if (ml[s] > 0) access("R3/R6 last offset", s, (ml[s] - 1) % 256, t);
                if (ml[s] < 256) access("R3 offset at limit", s, ml[s], t);
                access("R3/R5 offset 255", s, 255, t);
            end

        // R9: unprivileged writes ignored
        wr_ent(0, 1, 100, 3, 7);
        wr_len(0, 8);
        access("R9 seg 7 still illegal", 7, 0, 0);
        access("R9 entry 1 unchanged", 1, 10, 0);
        access("R9 entry 1 limit unchanged", 1, 20, 0);

        // R2: widen the table, seg 7 now legal (full 256 length, rwx)
        mlen = 8; wr_len(1, 8);
        access("R2 seg 7 legal", 7, 255, 2);
        access("R2 seg 6 legal write", 6, 3, 1);
        access("R4 reserved type", 7, 1, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule